// File: doc/BRIEF.md
# Instruction Decode and Integer Execute

This block is the combinational decode-and-execute slice of a 32-bit load/store processor with 32 general registers. It takes one instruction word and the two source register values already read from the register file, and in the same cycle returns the destination register index, a write enable and the integer result. It covers arithmetic, logic, compare, sign-extend, shift, multiply and unsigned divide. Multiply and divide are produced in a single step. Instructions that belong to other units (memory access, branches, calls, control register moves, system calls) pass through with no register write and no fault, so the neighbouring logic can act on them.

Bit 31 of the word alone chooses between the two-register form (set) and the register-plus-immediate form (clear). Most operations sit at the same low five opcode bits in both halves of the 64-entry opcode space. Each operation applies its own extension rule to the 16-bit immediate. Parameters remove the barrel shifter, the multiplier, the divider and the sign extender. When one of those units is absent, its instructions raise the illegal output. The one exception is a right shift by exactly one, which stays legal without the shifter.

Opcode values (immediate form / register form): logical right shift 0/32, NOR 1/33, multiply 2/34, arithmetic right shift 5/37, XOR 6/38, AND 8/40, XNOR 9/41, add 13/45, OR 14/46, left shift 15/47, equal 25/57, greater 26/58, greater-or-equal 27/59, greater-or-equal-unsigned 28/60, greater-unsigned 29/61, not-equal 31/63. Immediate-only: AND-high 24, OR-high 30. Register-only: unsigned divide 35, byte sign-extend 44, unsigned modulo 49, subtract 50, halfword sign-extend 55.

Top module: `dx_core`

## Requirements
- R1: Opcode is bits 31:26. In register form (bit 31 = 1) the destination index is bits 15:11 and the second operand is the second register value. In immediate form (bit 31 = 0) the destination is bits 20:16 and the second operand comes from the immediate in bits 15:0. Add (13/45) and subtract (50) give the wrapped 32-bit sum and difference.
- R2: Add, multiply and the signed compares (25, 26, 27, 31) sign-extend the 16-bit immediate. AND, OR, XOR, NOR, XNOR (8, 14, 6, 1, 9) and the unsigned compares (28, 29) zero-extend it. NOR and XNOR give the inverted OR and inverted XOR.
- R3: AND-high (24) and OR-high (30) place the immediate in bits 31:16, with zeros below, before the logic operation.
- R4: Compares write exactly 1 when the relation holds and 0 otherwise. The greater and greater-or-equal forms are signed, and their unsigned forms treat both operands as unsigned.
- R5: Shifts take their amount from bits 4:0 of the second operand: the second register value in register form, the instruction's bits 4:0 in immediate form. Left shift fills with zeros, opcode 5/37 shifts right arithmetically and 0/32 shifts right logically.
- R6: When HAS_SHIFTER is 0, left shifts are illegal, and right shifts are illegal unless the amount is exactly 1.
- R7: Multiply returns the low 32 bits of the product and is illegal when HAS_MUL is 0. Byte sign-extend (44) and halfword sign-extend (55) sign-extend bits 7:0 or 15:0 of the first operand, and both are illegal when HAS_SEXT is 0.
- R8: Unsigned divide (35) and modulo (49) return the quotient and the remainder. Both are illegal when HAS_DIV is 0. With the divider present, a zero divisor raises div_zero and suppresses the write.
- R9: A register-form AND (40) whose three register fields are all zero raises halt and writes nothing. Any other AND is an ordinary logic operation.
- R10: A destination of register 0 never produces a write enable.
- R11: Opcodes 39, 42, 51 and 53 raise illegal and write nothing.
- R12: Opcodes owned by other units (memory, branch, call, control register and system, such as 10, 22, 52 and 56) produce no write, no illegal, no halt and no div_zero.
- R13: Illegal, halt and div_zero never coincide, and none of them is raised together with a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| src_a_i | input | DATA_W | First source register value |
| src_b_i | input | DATA_W | Second source register value |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| result_o | output | DATA_W | Result, valid when wr_en_o is high |
| illegal_o | output | 1 | Illegal or absent-unit instruction |
| halt_o | output | 1 | Halt request |
| div_zero_o | output | 1 | Divide-by-zero fault |

## Verification
The bench builds two copies side by side on the same inputs. One has every optional unit present, which exercises the real multiply, divide, sign-extend and barrel-shift results together with the zero-divisor fault. The other has all four units removed, which exercises the illegal paths: a shift by one stays legal while other amounts fail, and a divide with a zero divisor reports illegal rather than div_zero.

// File: rtl/dx_pkg.sv
package dx_pkg;

  typedef enum logic [4:0] {
    OP_NONE, OP_ILL, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR, OP_XNOR,
    OP_CEQ, OP_CNE, OP_CGT, OP_CGE, OP_CGTU, OP_CGEU,
    OP_SLL, OP_SRA, OP_SRL, OP_MUL, OP_DIVU, OP_MODU, OP_SEXTB, OP_SEXTH
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SEXT, IMM_ZEXT, IMM_HIGH
  } imm_kind_e;

  typedef struct packed {
    alu_op_e   op;
    imm_kind_e ik;
    logic      is_rr;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [4:0] rd_rr;
    logic [15:0] imm;
  } dec_t;

endpackage

// File: rtl/dx_decode.sv
module dx_decode
  import dx_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o,
  output logic [4:0]  dest_o
);

  logic [5:0] opc;
  assign opc = instr_i[31:26];

  always_comb begin
    dec_o.is_rr = instr_i[31];
    dec_o.rs1   = instr_i[25:21];
    dec_o.rs2   = instr_i[20:16];
    dec_o.rd_rr = instr_i[15:11];
    dec_o.imm   = instr_i[15:0];
    dec_o.op    = OP_NONE;
    dec_o.ik    = IMM_ZEXT;
    case (opc)
      6'd0,  6'd32: dec_o.op = OP_SRL;
      6'd1,  6'd33: dec_o.op = OP_NOR;
      6'd2,  6'd34: begin dec_o.op = OP_MUL; dec_o.ik = IMM_SEXT; end
      6'd5,  6'd37: dec_o.op = OP_SRA;
      6'd6,  6'd38: dec_o.op = OP_XOR;
      6'd8,  6'd40: dec_o.op = OP_AND;
      6'd9,  6'd41: dec_o.op = OP_XNOR;
      6'd13, 6'd45: begin dec_o.op = OP_ADD; dec_o.ik = IMM_SEXT; end
      6'd14, 6'd46: dec_o.op = OP_OR;
      6'd15, 6'd47: dec_o.op = OP_SLL;
      6'd24:        begin dec_o.op = OP_AND; dec_o.ik = IMM_HIGH; end
      6'd30:        begin dec_o.op = OP_OR;  dec_o.ik = IMM_HIGH; end
      6'd25, 6'd57: begin dec_o.op = OP_CEQ; dec_o.ik = IMM_SEXT; end
      6'd26, 6'd58: begin dec_o.op = OP_CGT; dec_o.ik = IMM_SEXT; end
      6'd27, 6'd59: begin dec_o.op = OP_CGE; dec_o.ik = IMM_SEXT; end
      6'd28, 6'd60: dec_o.op = OP_CGEU;
      6'd29, 6'd61: dec_o.op = OP_CGTU;
      6'd31, 6'd63: begin dec_o.op = OP_CNE; dec_o.ik = IMM_SEXT; end
      6'd35:        dec_o.op = OP_DIVU;
      6'd49:        dec_o.op = OP_MODU;
      6'd44:        dec_o.op = OP_SEXTB;
      6'd55:        dec_o.op = OP_SEXTH;
      6'd50:        dec_o.op = OP_SUB;
      6'd39, 6'd42, 6'd51, 6'd53: dec_o.op = OP_ILL;
      default:      dec_o.op = OP_NONE;
    endcase
  end

  assign dest_o = instr_i[31] ? instr_i[15:11] : instr_i[20:16];

  always_comb begin
    if (!$isunknown(instr_i)) begin
      // R11: the undefined codes must always decode as illegal
      a_r11_undef_decodes_ill: assert (!(opc == 6'd39 || opc == 6'd42 ||
                                         opc == 6'd51 || opc == 6'd53) ||
                                       dec_o.op == OP_ILL);
    end
  end

endmodule

// File: rtl/dx_operand.sv
module dx_operand
  import dx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] opb_o
);

  localparam int PAD_W = DATA_W - 16;

  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    case (dec_i.ik)
      IMM_SEXT: imm_ext = {{PAD_W{dec_i.imm[15]}}, dec_i.imm};
      IMM_HIGH: imm_ext = {dec_i.imm, {PAD_W{1'b0}}};
      default:  imm_ext = {{PAD_W{1'b0}}, dec_i.imm};
    endcase
  end

  assign opb_o = dec_i.is_rr ? src_b_i : imm_ext;

endmodule

// File: rtl/dx_exec.sv
module dx_exec
  import dx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o
);

  localparam int SH_W  = $clog2(DATA_W);
  localparam int PRD_W = 2 * DATA_W;

  logic [SH_W-1:0]   amt;
  logic [PRD_W-1:0]  prod;
  logic [DATA_W-1:0] quo;
  logic [DATA_W-1:0] rem;
  logic              b_zero;
  logic              rel;

  assign amt    = b_i[SH_W-1:0];
  assign prod   = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
  assign b_zero = (b_i == '0);
  assign quo    = b_zero ? '0 : a_i / b_i;
  assign rem    = b_zero ? '0 : a_i % b_i;

  always_comb begin
    case (op_i)
      OP_CEQ:  rel = (a_i == b_i);
      OP_CNE:  rel = (a_i != b_i);
      OP_CGT:  rel = ($signed(a_i) >  $signed(b_i));
      OP_CGE:  rel = ($signed(a_i) >= $signed(b_i));
      OP_CGTU: rel = (a_i >  b_i);
      OP_CGEU: rel = (a_i >= b_i);
      default: rel = 1'b0;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_ADD:   result_o = a_i + b_i;
      OP_SUB:   result_o = a_i - b_i;
      OP_AND:   result_o = a_i & b_i;
      OP_OR:    result_o = a_i | b_i;
      OP_XOR:   result_o = a_i ^ b_i;
      OP_NOR:   result_o = ~(a_i | b_i);
      OP_XNOR:  result_o = ~(a_i ^ b_i);
      OP_CEQ, OP_CNE, OP_CGT, OP_CGE, OP_CGTU, OP_CGEU:
                result_o = {{(DATA_W-1){1'b0}}, rel};
      OP_SLL:   result_o = a_i << amt;
      OP_SRA:   result_o = DATA_W'($signed(a_i) >>> amt);
      OP_SRL:   result_o = a_i >> amt;
      OP_MUL:   result_o = prod[DATA_W-1:0];
      OP_DIVU:  result_o = quo;
      OP_MODU:  result_o = rem;
      OP_SEXTB: result_o = {{(DATA_W-8){a_i[7]}}, a_i[7:0]};
      OP_SEXTH: result_o = {{(DATA_W-16){a_i[15]}}, a_i[15:0]};
      default:  result_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i})) begin
      // R4: compare results are boolean
      a_r4_cmp_boolean: assert (!(op_i inside {OP_CEQ, OP_CNE, OP_CGT, OP_CGE,
                                               OP_CGTU, OP_CGEU}) ||
                                result_o[DATA_W-1:1] == '0);
      // R4: equal and not-equal are complementary on the same operands
      a_r4_eq_ne: assert (!(op_i == OP_CEQ && a_i != b_i) || result_o == '0);
    end
  end

endmodule

// File: rtl/dx_gate.sv
module dx_gate
  import dx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter bit HAS_SHIFTER = 1'b1,
  parameter bit HAS_MUL     = 1'b1,
  parameter bit HAS_DIV     = 1'b1,
  parameter bit HAS_SEXT    = 1'b1
) (
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [4:0]        dest_i,
  output logic              wr_en_o,
  output logic              illegal_o,
  output logic              halt_o,
  output logic              div_zero_o
);

  localparam int SH_W = $clog2(DATA_W);

  logic amt_is_one;
  logic is_div;
  logic bad_shift, bad_mul, bad_div, bad_sext;

  assign amt_is_one = (opb_i[SH_W-1:0] == SH_W'(1));
  assign is_div     = (dec_i.op == OP_DIVU) || (dec_i.op == OP_MODU);

  assign bad_shift = !HAS_SHIFTER &&
                     ((dec_i.op == OP_SLL) ||
                      ((dec_i.op == OP_SRA || dec_i.op == OP_SRL) && !amt_is_one));
  assign bad_mul   = !HAS_MUL  && (dec_i.op == OP_MUL);
  assign bad_div   = !HAS_DIV  && is_div;
  assign bad_sext  = !HAS_SEXT && (dec_i.op == OP_SEXTB || dec_i.op == OP_SEXTH);

  assign illegal_o  = (dec_i.op == OP_ILL) || bad_shift || bad_mul || bad_div || bad_sext;
  assign halt_o     = dec_i.is_rr && (dec_i.op == OP_AND) &&
                      (dec_i.rs1 == 5'd0) && (dec_i.rs2 == 5'd0) && (dec_i.rd_rr == 5'd0);
  assign div_zero_o = HAS_DIV && is_div && (opb_i == '0);

  assign wr_en_o = (dec_i.op != OP_NONE) && !illegal_o && !halt_o &&
                   !div_zero_o && (dest_i != 5'd0);

endmodule

// File: rtl/dx_core.sv
module dx_core
  import dx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter bit HAS_SHIFTER = 1'b1,
  parameter bit HAS_MUL     = 1'b1,
  parameter bit HAS_DIV     = 1'b1,
  parameter bit HAS_SEXT    = 1'b1
) (
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [4:0]        dest_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o,
  output logic              halt_o,
  output logic              div_zero_o
);

  dec_t              dec;
  logic [DATA_W-1:0] opb;

  dx_decode u_decode (
    .instr_i (instr_i),
    .dec_o   (dec),
    .dest_o  (dest_o)
  );

  dx_operand #(.DATA_W(DATA_W)) u_operand (
    .dec_i   (dec),
    .src_b_i (src_b_i),
    .opb_o   (opb)
  );

  dx_exec #(.DATA_W(DATA_W)) u_exec (
    .op_i     (dec.op),
    .a_i      (src_a_i),
    .b_i      (opb),
    .result_o (result_o)
  );

  dx_gate #(
    .DATA_W      (DATA_W),
    .HAS_SHIFTER (HAS_SHIFTER),
    .HAS_MUL     (HAS_MUL),
    .HAS_DIV     (HAS_DIV),
    .HAS_SEXT    (HAS_SEXT)
  ) u_gate (
    .dec_i      (dec),
    .opb_i      (opb),
    .dest_i     (dest_o),
    .wr_en_o    (wr_en_o),
    .illegal_o  (illegal_o),
    .halt_o     (halt_o),
    .div_zero_o (div_zero_o)
  );

  always_comb begin
    if (!$isunknown({instr_i, src_a_i, src_b_i})) begin
      // R10
      a_r10_no_r0_write: assert (!wr_en_o || dest_o != 5'd0);
      // R13
      a_r13_faults_exclusive: assert ($onehot0({illegal_o, halt_o, div_zero_o}));
      // R13
      a_r13_fault_no_write: assert (!(wr_en_o && (illegal_o || halt_o || div_zero_o)));
      // R8: a zero divisor with the divider present never writes
      a_r8_zero_divisor: assert (!(HAS_DIV && instr_i[31:26] == 6'd35 &&
                                   src_b_i == '0) || (div_zero_o && !wr_en_o));
      // R6: left shift without the shifter always faults
      a_r6_sll_absent: assert (HAS_SHIFTER || instr_i[30:26] != 5'd15 || illegal_o);
      // R12: an opcode owned by another unit neither writes nor faults
      a_r12_foreign_quiet: assert (!(instr_i[31:26] inside {6'd10, 6'd22, 6'd52, 6'd56}) ||
                                   !(wr_en_o || illegal_o || halt_o || div_zero_o));
    end
  end

endmodule

// File: tb/tb_dx_core.sv
module tb_dx_core;

  localparam int W = 32;

  logic clk;
  logic rst_n;
  logic [31:0]  instr;
  logic [W-1:0] a, b;

  logic [4:0]   f_dest, m_dest;
  logic         f_wr, m_wr, f_ill, m_ill, f_halt, m_halt, f_dz, m_dz;
  logic [W-1:0] f_res, m_res;

  dx_core #(.DATA_W(W)) dut (
    .instr_i(instr), .src_a_i(a), .src_b_i(b),
    .dest_o(f_dest), .wr_en_o(f_wr), .result_o(f_res),
    .illegal_o(f_ill), .halt_o(f_halt), .div_zero_o(f_dz)
  );

  dx_core #(.DATA_W(W), .HAS_SHIFTER(1'b0), .HAS_MUL(1'b0),
            .HAS_DIV(1'b0), .HAS_SEXT(1'b0)) dut_min (
    .instr_i(instr), .src_a_i(a), .src_b_i(b),
    .dest_o(m_dest), .wr_en_o(m_wr), .result_o(m_res),
    .illegal_o(m_ill), .halt_o(m_halt), .div_zero_o(m_dz)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    string        tag;
    bit           full;
    bit [4:0]     dest;
    bit           wr;
    bit [W-1:0]   res;
    bit           ill;
    bit           halt;
    bit           dz;
  } item_t;

  item_t sb[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  function automatic logic [31:0] ri(int op, int rs, int rt, logic [15:0] imm);
    ri = {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] rr(int op, int rs1, int rs2, int rd);
    rr = {op[5:0], rs1[4:0], rs2[4:0], rd[4:0], 11'd0};
  endfunction

  task automatic drive(string tag, bit full, logic [31:0] ins, logic [W-1:0] va,
                       logic [W-1:0] vb, bit wr, bit [4:0] dest, bit [W-1:0] res,
                       bit ill, bit halt, bit dz);
    item_t it;
    @(posedge clk);
    instr = ins; a = va; b = vb;
    it.tag = tag; it.full = full; it.dest = dest; it.wr = wr; it.res = res;
    it.ill = ill; it.halt = halt; it.dz = dz;
    sb.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t e;
      bit [4:0] gd; bit gw, gi, gh, gz; bit [W-1:0] gr;
      bit ok;
      e = sb.pop_front();
      if (e.full) begin gd = f_dest; gw = f_wr; gr = f_res; gi = f_ill; gh = f_halt; gz = f_dz; end
      else        begin gd = m_dest; gw = m_wr; gr = m_res; gi = m_ill; gh = m_halt; gz = m_dz; end
      ok = (gw == e.wr) && (gi == e.ill) && (gh == e.halt) && (gz == e.dz);
      if (e.wr) ok = ok && (gd == e.dest) && (gr == e.res);
      n_checks++;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s: wr=%0d dest=%0d res=%h ill=%0d halt=%0d dz=%0d expected wr=%0d dest=%0d res=%h ill=%0d halt=%0d dz=%0d",
                 e.tag, gw, gd, gr, gi, gh, gz, e.wr, e.dest, e.res, e.ill, e.halt, e.dz);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    instr = '0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10 idle word: opcode 0 into r0
    drive("R10 idle word", 1, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1 / R2 add immediate sign-extended
    drive("R1 addi", 1, ri(13, 1, 5, 16'hFFFF), 10, 0, 1, 5, 9, 0, 0, 0);
    drive("R1 add rr", 1, rr(45, 1, 2, 7), 5, 6, 1, 7, 11, 0, 0, 0);
    drive("R1 sub wrap", 1, rr(50, 1, 2, 9), 3, 5, 1, 9, 32'hFFFF_FFFE, 0, 0, 0);
    // R2 zero extension
    drive("R2 ori zext", 1, ri(14, 1, 3, 16'h8000), 1, 0, 1, 3, 32'h0000_8001, 0, 0, 0);
    drive("R2 xnori", 1, ri(9, 1, 3, 16'h00FF), 32'h0F, 0, 1, 3, 32'hFFFF_FF0F, 0, 0, 0);
    drive("R2 nor rr", 1, rr(33, 1, 2, 4), 0, 0, 1, 4, 32'hFFFF_FFFF, 0, 0, 0);
    drive("R2 cmpgei sext", 1, ri(27, 1, 3, 16'hFFFF), 0, 0, 1, 3, 1, 0, 0, 0);
    drive("R2 cmpgeui zext", 1, ri(28, 1, 3, 16'hFFFF), 0, 0, 1, 3, 0, 0, 0, 0);
    drive("R2 muli sext", 1, ri(2, 1, 3, 16'hFFFE), 5, 0, 1, 3, 32'hFFFF_FFF6, 0, 0, 0);
    // R3 high immediates
    drive("R3 andhi", 1, ri(24, 1, 4, 16'h00FF), 32'hFFFF_FFFF, 0, 1, 4, 32'h00FF_0000, 0, 0, 0);
    drive("R3 orhi", 1, ri(30, 0, 4, 16'h1234), 32'h0000_5678, 0, 1, 4, 32'h1234_5678, 0, 0, 0);
    // R4 compares
    drive("R4 cmpg signed", 1, rr(58, 1, 2, 6), 32'hFFFF_FFFF, 1, 1, 6, 0, 0, 0, 0);
    drive("R4 cmpgu unsigned", 1, rr(61, 1, 2, 6), 32'hFFFF_FFFF, 1, 1, 6, 1, 0, 0, 0);
    drive("R4 cmpe equal", 1, rr(57, 1, 2, 6), 32'h55, 32'h55, 1, 6, 1, 0, 0, 0);
    drive("R4 cmpne equal", 1, rr(63, 1, 2, 6), 32'h55, 32'h55, 1, 6, 0, 0, 0, 0);
    // R5 shifts
    drive("R5 sl low5", 1, rr(47, 1, 2, 8), 1, 32'h21, 1, 8, 2, 0, 0, 0);
    drive("R5 sr arith", 1, rr(37, 1, 2, 8), 32'h8000_0000, 4, 1, 8, 32'hF800_0000, 0, 0, 0);
    drive("R5 sru logic", 1, rr(32, 1, 2, 8), 32'h8000_0000, 4, 1, 8, 32'h0800_0000, 0, 0, 0);
    drive("R5 sri 31", 1, ri(5, 1, 3, 16'h001F), 32'h8000_0000, 0, 1, 3, 32'hFFFF_FFFF, 0, 0, 0);
    drive("R5 sli imm bits4:0", 1, ri(15, 1, 3, 16'hFFE3), 1, 0, 1, 3, 8, 0, 0, 0);
    // R7 multiply and sign extend
    drive("R7 mul", 1, rr(34, 1, 2, 10), 7, 32'hFFFF_FFFD, 1, 10, 32'hFFFF_FFEB, 0, 0, 0);
    drive("R7 sextb", 1, rr(44, 1, 0, 6), 32'h80, 0, 1, 6, 32'hFFFF_FF80, 0, 0, 0);
    drive("R7 sexth", 1, rr(55, 1, 0, 6), 32'h0001_7FFF, 0, 1, 6, 32'h0000_7FFF, 0, 0, 0);
    // R8 divide
    drive("R8 divu", 1, rr(35, 1, 2, 11), 100, 7, 1, 11, 14, 0, 0, 0);
    drive("R8 modu", 1, rr(49, 1, 2, 11), 100, 7, 1, 11, 2, 0, 0, 0);
    drive("R8 divu by zero", 1, rr(35, 1, 2, 11), 100, 0, 0, 11, 0, 0, 0, 1);
    drive("R8 modu by zero", 1, rr(49, 1, 2, 11), 100, 0, 0, 11, 0, 0, 0, 1);
    // R9 halt
    drive("R9 halt", 1, rr(40, 0, 0, 0), 32'hF0, 32'h3C, 0, 0, 0, 0, 1, 0);
    drive("R9 and not halt", 1, rr(40, 0, 0, 3), 32'hF0, 32'h3C, 1, 3, 32'h30, 0, 0, 0);
    drive("R9 andi all zero", 1, ri(8, 0, 0, 16'h0), 0, 0, 0, 0, 0, 0, 0, 0);
    // R10 r0 destination
    drive("R10 addi to r0", 1, ri(13, 1, 0, 16'h5), 1, 0, 0, 0, 0, 0, 0, 0);
    drive("R10 add rr to r0", 1, rr(45, 1, 2, 0), 1, 2, 0, 0, 0, 0, 0, 0);
    // R11 undefined
    drive("R11 op39", 1, rr(39, 1, 2, 3), 0, 0, 0, 3, 0, 1, 0, 0);
    drive("R11 op42", 1, rr(42, 1, 2, 3), 0, 0, 0, 3, 0, 1, 0, 0);
    drive("R11 op51", 1, rr(51, 1, 2, 3), 0, 0, 0, 3, 0, 1, 0, 0);
    drive("R11 op53", 1, rr(53, 1, 2, 3), 0, 0, 0, 3, 0, 1, 0, 0);
    // R12 foreign
    drive("R12 op10", 1, ri(10, 1, 3, 16'h4), 0, 0, 0, 3, 0, 0, 0, 0);
    drive("R12 op22", 1, ri(22, 1, 3, 16'h4), 0, 0, 0, 3, 0, 0, 0, 0);
    drive("R12 op52", 1, rr(52, 1, 2, 3), 0, 0, 0, 3, 0, 0, 0, 0);
    drive("R12 op56", 1, 32'hE000_0010, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 no shifter
    drive("R6 sl absent", 0, rr(47, 1, 2, 8), 1, 1, 0, 8, 0, 1, 0, 0);
    drive("R6 sri by 1", 0, ri(5, 1, 3, 16'h0001), 32'h8000_0000, 0, 1, 3, 32'hC000_0000, 0, 0, 0);
    drive("R6 sri by 2", 0, ri(5, 1, 3, 16'h0002), 32'h8000_0000, 0, 0, 3, 0, 1, 0, 0);
    drive("R6 sru rr amt 33", 0, rr(32, 1, 2, 8), 32'h8000_0000, 33, 1, 8, 32'h4000_0000, 0, 0, 0);
    drive("R6 sru rr amt 0", 0, rr(32, 1, 2, 8), 32'h8000_0000, 0, 0, 8, 0, 1, 0, 0);
    // R7 / R8 absent units
    drive("R7 mul absent", 0, rr(34, 1, 2, 10), 7, 3, 0, 10, 0, 1, 0, 0);
    drive("R7 sextb absent", 0, rr(44, 1, 0, 6), 32'h80, 0, 0, 6, 0, 1, 0, 0);
    drive("R8 divu absent zero", 0, rr(35, 1, 2, 11), 100, 0, 0, 11, 0, 1, 0, 0);
    drive("R8 modu absent", 0, rr(49, 1, 2, 11), 100, 7, 0, 11, 0, 1, 0, 0);
    drive("R13 add on min", 0, rr(45, 1, 2, 7), 5, 6, 1, 7, 11, 0, 0, 0);

    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule